// File: doc/BRIEF.md
# Dual-Half Square-Wave Timer

This block is a programmable down-counting timer for a byte-wide register bus. Software writes a 14-bit count length and a 2-bit mode into two staging bytes, then issues commands through a command byte. Once started, the timer consumes one count step per asserted `cnt_tick_i` cycle. It splits each period into two halves and decrements by two per step. The output `tmr_out_o` carries either a square wave or a one-step low pulse just before terminal count.

A sticky terminal-count flag is raised once per period and cleared by a read strobe. The mode has two bits. One selects pulse shaping instead of square-wave shaping. The other makes the timer reload and keep running at terminal count instead of stopping. Commands can stop the timer at once, let it finish the current period, or start it. A start issued while the timer runs is deferred to the next terminal count.

Top module: `sq_timer`

## Requirements
- R1: After reset the timer is idle, `tmr_out_o` is 1 and `tc_flag_o` is 0; whenever the timer is idle `tmr_out_o` is 1.
- R2: Register map. Address 1 holds count bits 7:0. Address 2 holds count bits 13:8 in data bits 5:0 and the mode in data bits 7:6: bit 7 selects pulse shaping and bit 6 selects auto-reload. Address 0 is the command byte, whose code sits in data bits 1:0: 0 no effect, 1 stop now, 2 stop after terminal count, 3 start. Writing the count bytes never disturbs a running period.
- R3: In square-wave modes a period of length N (N >= 2) keeps `tmr_out_o` high for the first ceil(N/2) steps after loading and low for the next floor(N/2) steps. The output returns high on step N.
- R4: In pulse modes with N >= 4, `tmr_out_o` is low only between step N-1 and step N of each period.
- R5: `tc_flag_o` is set on step N-1 of every period when N >= 4, and on step N when N is 2 or 3. It then stays set until cleared.
- R6: A `stat_rd_i` cycle clears the flag. If the flag is set in that same cycle, the flag stays set.
- R7: Without auto-reload the timer stops after step N. No further output change or flag follows.
- R8: With auto-reload the timer reloads at step N from the count and mode currently in the staging bytes, and keeps running.
- R9: A stop-now command idles the timer on the next clock with `tmr_out_o` high. On an idle timer it has no effect.
- R10: A stop-after-terminal-count command lets the current period finish and then idles the timer, even with auto-reload.
- R11: A start command on an idle timer loads the staging count and mode at once. On a running timer the current period completes unchanged, and the staging count and mode take over from the next terminal count, even in a single-shot mode.
- R12: Starting with a count below 2 leaves the timer idle with `tmr_out_o` high, and no flag is set.
- R13: Only cycles with `cnt_tick_i` high advance the count. A tick in the same cycle as a command write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 8 | Register write data |
| cnt_tick_i | input | 1 | Count step enable |
| stat_rd_i | input | 1 | Status read strobe, clears the flag |
| tmr_out_o | output | 1 | Timer output |
| tc_flag_o | output | 1 | Sticky terminal-count flag |

## Verification
A wrong counter value or a lost odd-count extra step moves the falling or rising edge of `tmr_out_o` by one or more steps within the same period. The scoreboard compares the output after every tick, so such a fault is visible within one period. A wrong pending-command bit shows only at the next terminal count: the timer keeps running or stops, or it runs a period of the wrong length or shape. For this reason each command scenario runs one period past that point. Flag faults show at the first read or set event after the fault.

// File: rtl/sqt_pkg.sv
package sqt_pkg;
  typedef enum logic [1:0] {
    CMD_NOP     = 2'd0,
    CMD_STOP    = 2'd1,
    CMD_STOP_TC = 2'd2,
    CMD_START   = 2'd3
  } sqt_cmd_e;

  localparam logic [1:0] ADDR_CMD    = 2'd0;
  localparam logic [1:0] ADDR_CNT_LO = 2'd1;
  localparam logic [1:0] ADDR_CNT_HI = 2'd2;

  localparam int MODE_AUTO_BIT  = 0;
  localparam int MODE_PULSE_BIT = 1;
endpackage

// File: rtl/sqt_regs.sv
module sqt_regs
  import sqt_pkg::*;
#(
  parameter int CNT_W  = 14,
  parameter int ADDR_W = 2,
  localparam int CFG_W = CNT_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic [CFG_W-1:0]  cfg_o,
  output logic              cmd_vld_o,
  output sqt_cmd_e          cmd_o
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_W'(ADDR_CNT_LO)) cfg_q[7:0] <= wr_data_i;
      if (wr_addr_i == ADDR_W'(ADDR_CNT_HI)) cfg_q[CFG_W-1:8] <= wr_data_i[CFG_W-9:0];
    end
  end

  assign cfg_o     = cfg_q;
  assign cmd_vld_o = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CMD));
  assign cmd_o     = sqt_cmd_e'(wr_data_i[1:0]);
endmodule

// File: rtl/sqt_core.sv
module sqt_core
  import sqt_pkg::*;
#(
  parameter int CNT_W  = 14,
  localparam int CFG_W = CNT_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cmd_vld_i,
  input  sqt_cmd_e         cmd_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             to_o,
  output logic             run_o,
  output logic             tc_evt_o
);
  logic [CNT_W-1:0] cnt_q, act_q, cnt_nxt, cfg_cnt;
  logic [1:0]       mode_q, cfg_mode;
  logic             run_q, extra_q, to_q, stop_tc_q, start_pend_q;
  logic             adv, at_one, at_two, at_zero, restart, ld_now, ld_ok;

  assign cfg_cnt  = cfg_i[CNT_W-1:0];
  assign cfg_mode = cfg_i[CFG_W-1:CNT_W];
  assign ld_ok    = cfg_cnt >= CNT_W'(2);
  assign cnt_nxt  = cnt_q - CNT_W'(2);

  always_comb begin
    adv     = tick_i && run_q && !cmd_vld_i && !extra_q;
    at_one  = adv && (cnt_nxt == CNT_W'(1));
    at_two  = adv && (cnt_nxt == CNT_W'(2));
    at_zero = adv && (cnt_nxt == '0);
    restart = at_zero && (start_pend_q || (mode_q[MODE_AUTO_BIT] && !stop_tc_q));
    ld_now  = restart || (cmd_vld_i && cmd_i == CMD_START && !run_q);
  end

  // short counts (2, 3) never pass through 2 in the second half
  assign tc_evt_o = at_two || (at_zero && act_q < CNT_W'(4));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q        <= '0;
      act_q        <= '0;
      mode_q       <= '0;
      run_q        <= 1'b0;
      extra_q      <= 1'b0;
      to_q         <= 1'b1;
      stop_tc_q    <= 1'b0;
      start_pend_q <= 1'b0;
    end else if (ld_now) begin
      to_q         <= 1'b1;
      stop_tc_q    <= 1'b0;
      start_pend_q <= 1'b0;
      run_q        <= ld_ok;
      extra_q      <= ld_ok && cfg_cnt[0];
      if (ld_ok) begin
        act_q  <= cfg_cnt;
        mode_q <= cfg_mode;
        cnt_q  <= {cfg_cnt[CNT_W-1:1], 1'b1};
      end
    end else if (cmd_vld_i) begin
      unique case (cmd_i)
        CMD_STOP: begin
          run_q        <= 1'b0;
          to_q         <= 1'b1;
          extra_q      <= 1'b0;
          stop_tc_q    <= 1'b0;
          start_pend_q <= 1'b0;
        end
        CMD_STOP_TC: if (run_q) begin
          stop_tc_q    <= 1'b1;
          start_pend_q <= 1'b0;
        end
        CMD_START: if (run_q) begin
          start_pend_q <= 1'b1;
          stop_tc_q    <= 1'b0;
        end
        default: ;
      endcase
    end else if (tick_i && run_q && extra_q) begin
      extra_q <= 1'b0;
    end else if (at_one) begin
      cnt_q <= {act_q[CNT_W-1:1], 1'b0};
      if (!mode_q[MODE_PULSE_BIT]) to_q <= 1'b0;
    end else if (at_two) begin
      cnt_q <= cnt_nxt;
      if (mode_q[MODE_PULSE_BIT]) to_q <= 1'b0;
    end else if (at_zero) begin
      to_q         <= 1'b1;
      run_q        <= 1'b0;
      stop_tc_q    <= 1'b0;
      start_pend_q <= 1'b0;
    end else if (adv) begin
      cnt_q <= cnt_nxt;
    end
  end

  assign to_o  = to_q;
  assign run_o = run_q;
endmodule

// File: rtl/sqt_flag.sv
module sqt_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= set_i || (flag_q && !clr_i);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/sq_timer.sv
module sq_timer
  import sqt_pkg::*;
#(
  parameter int CNT_W  = 14,
  parameter int ADDR_W = 2,
  localparam int CFG_W = CNT_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              cnt_tick_i,
  input  logic              stat_rd_i,
  output logic              tmr_out_o,
  output logic              tc_flag_o
);
  logic [CFG_W-1:0] cfg_w;
  logic             cmd_vld_w, run_w, tc_evt_w;
  sqt_cmd_e         cmd_w;

  sqt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .cfg_o(cfg_w), .cmd_vld_o(cmd_vld_w), .cmd_o(cmd_w)
  );

  sqt_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni, .tick_i(cnt_tick_i), .cmd_vld_i(cmd_vld_w), .cmd_i(cmd_w),
    .cfg_i(cfg_w), .to_o(tmr_out_o), .run_o(run_w), .tc_evt_o(tc_evt_w)
  );

  sqt_flag u_flag (
    .clk_i, .rst_ni, .set_i(tc_evt_w), .clr_i(stat_rd_i), .flag_o(tc_flag_o)
  );
endmodule

// File: rtl/sq_timer_chk.sv
module sq_timer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick,
  input logic       cmd_vld,
  input logic [1:0] cmd,
  input logic       run,
  input logic       tc_evt,
  input logic       stat_rd,
  input logic       to,
  input logic       flag
);
  p_idle_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> to);
  p_stop_now_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_vld && cmd == 2'd1) |=> (!run && to));
  p_flag_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_evt |=> flag);
  p_flag_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag && !stat_rd) |=> flag);
  p_flag_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && !tc_evt) |=> !flag);
  p_no_tick_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !tick && !cmd_vld) |=> $stable(to));
  p_tick_with_cmd_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_vld && cmd == 2'd0) |=> $stable(to));
endmodule

bind sq_timer sq_timer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick(cnt_tick_i), .cmd_vld(cmd_vld_w),
  .cmd(cmd_w), .run(run_w), .tc_evt(tc_evt_w), .stat_rd(stat_rd_i),
  .to(tmr_out_o), .flag(tc_flag_o)
);

// File: tb/sq_timer_tb.sv
module sq_timer_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       cnt_tick_i = 1'b0;
  logic       stat_rd_i = 1'b0;
  logic       tmr_out_o, tc_flag_o;

  sq_timer u_dut (.*);

  always #5 clk_i = ~clk_i;

  typedef struct {
    bit    to;
    bit    flg;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   flg = 1'b0;
  bit   tick_d = 1'b0;
  bit   done = 1'b0;

  always @(posedge clk_i) tick_d <= cnt_tick_i;

  // monitor: one expected item per applied tick
  always @(negedge clk_i) begin
    if (tick_d && q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      n_chk += 2;
      if (tmr_out_o !== it.to) begin
        n_fail++;
        $display("FAIL %s tmr_out_o actual %0b expected %0b", it.tag, tmr_out_o, it.to);
      end
      if (tc_flag_o !== it.flg) begin
        n_fail++;
        $display("FAIL %s tc_flag_o actual %0b expected %0b", it.tag, tc_flag_o, it.flg);
      end
    end
  end

  task automatic check(input bit act, input bit exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0; cnt_tick_i = 1'b0; stat_rd_i = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    cyc();
  endtask

  task automatic cfg(input int n, input logic [1:0] mode);
    wr(2'd1, n[7:0]);
    wr(2'd2, {mode, n[13:8]});
  endtask

  task automatic cmd(input logic [1:0] c);
    wr(2'd0, {6'd0, c});
  endtask

  task automatic clr_flag();
    stat_rd_i = 1'b1;
    flg = 1'b0;
    cyc();
  endtask

  task automatic tick(input bit e_to, input bit setf, input bit rd, input string tag);
    exp_t it;
    flg = setf | (flg & ~rd);
    it.to = e_to; it.flg = flg; it.tag = tag;
    q.push_back(it);
    cnt_tick_i = 1'b1; stat_rd_i = rd;
    cyc();
  endtask

  task automatic tick_cmd(input bit e_to, input logic [1:0] c, input string tag);
    exp_t it;
    it.to = e_to; it.flg = flg; it.tag = tag;
    q.push_back(it);
    cnt_tick_i = 1'b1;
    wr_en_i = 1'b1; wr_addr_i = 2'd0; wr_data_i = {6'd0, c};
    cyc();
  endtask

  // expected per-step output and flag for one period of length n
  task automatic period(input int n, input bit pulse, input int from_i, input string tag);
    int hi;
    bit e_to, setf;
    hi = (n + 1) / 2;
    for (int i = from_i; i <= n; i++) begin
      if (pulse) e_to = (i != n - 1);
      else       e_to = !(i >= hi && i < n);
      setf = (n >= 4) ? (i == n - 1) : (i == n);
      tick(e_to, setf, 1'b0, tag);
    end
  endtask

  task automatic idle(input int k, input string tag);
    for (int i = 0; i < k; i++) tick(1'b1, 1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(tmr_out_o, 1'b1, "R1 reset output");
    check(tc_flag_o, 1'b0, "R1 reset flag");
    rst_ni = 1'b1;
    @(negedge clk_i);
    idle(2, "R1 idle ticks");

    // R3/R7: single square N=4, then stays stopped
    cfg(4, 2'b00); cmd(2'd3);
    period(4, 1'b0, 1, "R3 even square");
    idle(3, "R7 single stop");
    check(tc_flag_o, 1'b1, "R5 flag sticky");
    clr_flag();
    check(tc_flag_o, 1'b0, "R6 read clears");

    // R3 odd count
    cfg(5, 2'b00); cmd(2'd3);
    period(5, 1'b0, 1, "R3 odd square");
    idle(2, "R7 odd stop");
    clr_flag();

    // R4 single pulse
    cfg(6, 2'b10); cmd(2'd3);
    period(6, 1'b1, 1, "R4 pulse");
    idle(2, "R7 pulse stop");
    clr_flag();

    // R5 short counts
    cfg(2, 2'b00); cmd(2'd3);
    period(2, 1'b0, 1, "R5 count 2");
    clr_flag();
    cfg(3, 2'b00); cmd(2'd3);
    period(3, 1'b0, 1, "R5 count 3");
    idle(1, "R7 count 3 stop");
    clr_flag();

    // R8 auto-reload, R2 staging write mid-period, R6 same-cycle set/read, R10
    cfg(4, 2'b01); cmd(2'd3);
    period(4, 1'b0, 1, "R8 auto p1");
    clr_flag();
    tick(1'b1, 1'b0, 1'b0, "R8 auto p2");
    tick(1'b0, 1'b0, 1'b0, "R8 auto p2");
    cfg(6, 2'b01);
    tick(1'b0, 1'b1, 1'b1, "R6 set wins over read");
    tick(1'b1, 1'b0, 1'b0, "R2 count write kept out of period");
    clr_flag();
    period(6, 1'b0, 1, "R8 reload from staging");
    clr_flag();
    period(6, 1'b0, 1, "R8 auto p4");
    clr_flag();
    period(6, 1'b0, 1, "R10 prior");
    clr_flag();
    tick(1'b1, 1'b0, 1'b0, "R10 run");
    tick(1'b1, 1'b0, 1'b0, "R10 run");
    cmd(2'd2);
    period(6, 1'b0, 3, "R10 finish period");
    idle(3, "R10 stopped");
    clr_flag();

    // R9 stop now
    cmd(2'd1);
    check(tmr_out_o, 1'b1, "R9 stop on idle");
    idle(1, "R9 idle stop no effect");
    cfg(8, 2'b01); cmd(2'd3);
    period(8, 1'b0, 1, "R9 run");
    clr_flag();
    tick(1'b1, 1'b0, 1'b0, "R9 run");
    tick(1'b1, 1'b0, 1'b0, "R9 run");
    tick(1'b1, 1'b0, 1'b0, "R9 run");
    tick(1'b0, 1'b0, 1'b0, "R9 run low");
    cmd(2'd1);
    check(tmr_out_o, 1'b1, "R9 stop forces high");
    idle(6, "R9 stopped");

    // R11 start while running
    cfg(4, 2'b00); cmd(2'd3);
    tick(1'b1, 1'b0, 1'b0, "R11 first");
    cfg(6, 2'b10); cmd(2'd3);
    period(4, 1'b0, 2, "R11 current period kept");
    clr_flag();
    period(6, 1'b1, 1, "R11 new pulse period");
    idle(2, "R11 single stop");
    clr_flag();

    // R12 invalid count
    cfg(1, 2'b01); cmd(2'd3);
    idle(4, "R12 count 1 idle");
    cfg(0, 2'b00); cmd(2'd3);
    idle(2, "R12 count 0 idle");

    // R13 tick with command write ignored
    cfg(4, 2'b00); cmd(2'd3);
    tick(1'b1, 1'b0, 1'b0, "R13 first");
    tick_cmd(1'b1, 2'd0, "R13 tick ignored");
    period(4, 1'b0, 2, "R13 period intact");
    idle(2, "R13 stop");

    repeat (3) @(negedge clk_i);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule